// File: doc/BRIEF.md
# Triggered Pulse Timer

This block is a single timer channel that emits a repeating pulse-width-modulated waveform once it has been started by a trigger. When software sets the enable bit, the counter is held at its all-ones value and nothing happens until a trigger arrives. A trigger can come from a selectable edge on an external pin or from a self-clearing software trigger bit. From then on the counter advances by one on every count-enable strobe and wraps to zero at the period value. A second output toggles at every wrap.

Two registers hold the period and the duty. Each has a compare buffer, and the counter compares against the buffer. While the timer is disabled, a write goes straight into its buffer. While the timer is enabled, a write only updates the staging register. A later write to the duty register arms a reload, and the armed pair is copied into both buffers at the next period match. Any trigger that arrives while counting, whether it is the first one or a repeat, restarts the count from zero.

Top module: `trig_pulse_timer`

## Requirements
- R1: After reset, and while enabled but not yet triggered, the counter stays parked at all ones, `pulse_out` is 0, `period_tgl` is 0, and no count strobe changes either output.
- R2: With the edge-select bit (control bit 2) at 0, a rising edge on `trig_in` starts the count. The pin passes through a two-flop synchronizer, and the counter reads zero three clock edges after the pin changes.
- R3: With control bit 2 at 1, a falling edge on `trig_in` is the trigger and a rising edge has no effect.
- R4: A write to the control register (address 0) with bit 0 (enable) and bit 1 (software trigger) both set starts the count at the clock edge of that write. Bit 1 is not stored.
- R5: While the counter runs, it advances only on cycles with `cnt_tick` high. When it equals the period buffer on such a cycle, it goes to 0.
- R6: While running, `pulse_out` is 1 exactly when duty buffer <= count <= period buffer. It is therefore never active when duty > period, and always active when duty is 0.
- R7: `period_tgl` inverts on each period match and changes at no other time while running.
- R8: While disabled, a write to the period register (address 1) or the duty register (address 2) loads its compare buffer directly.
- R9: While enabled, a period write alone changes nothing. A duty write arms a reload that copies both staged values into the buffers at the next period match, and the armed state is then cleared.
- R10: Every trigger while enabled, including a repeated trigger during counting, sets the counter to 0 and restarts the count. A trigger takes priority over a simultaneous period match, which then neither toggles nor reloads.
- R11: Writing control bit 0 as 0 parks the counter, forces `pulse_out` and `period_tgl` to 0, and drops any armed reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 period, 2 duty, 3 ignored |
| wr_data | input | 16 | Write data |
| trig_in | input | 1 | External trigger pin (asynchronous) |
| cnt_tick | input | 1 | Count-enable strobe |
| pulse_out | output | 1 | Pulse waveform |
| period_tgl | output | 1 | Toggles on each period match |

## Verification
Every output is registered. The effect of a register write, a software trigger or a count strobe therefore appears one clock edge after the edge that samples it. A pin trigger takes three edges: two synchronizer stages, then the edge that acts on it. Inputs are driven and outputs compared on the falling clock edge. A cycle-level reference model in the bench advances on the rising edge from the same inputs. It keeps its own three-deep pin history, so each comparison falls in the cycle in which the requirements place the change. The period/duty sweep, pin triggers of both polarities, retriggers, staged reloads and disables are each compared on every cycle.

// File: rtl/tpt_pkg.sv
package tpt_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL   = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_DUTY   = 2'd2
    } reg_sel_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_SWT_BIT  = 1;
    localparam int CTRL_FALL_BIT = 2;
endpackage

// File: rtl/tpt_edge_sync.sv
module tpt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic edge_o
);
    localparam int LAST = STAGES;

    typedef struct packed {
        logic [LAST:0] sh;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.sh = {s_q.sh[LAST-1:0], pin_i};
        if (fall_sel_i)
            edge_o = ~s_q.sh[LAST-1] & s_q.sh[LAST];
        else
            edge_o = s_q.sh[LAST-1] & ~s_q.sh[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/tpt_compare_bank.sv
module tpt_compare_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enabled_i,
    input  logic         per_wr_i,
    input  logic         duty_wr_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         wrap_i,
    output logic [W-1:0] per_buf_o,
    output logic [W-1:0] duty_nxt_o,
    output logic         armed_o
);
    typedef struct packed {
        logic [W-1:0] per_stage;
        logic [W-1:0] duty_stage;
        logic [W-1:0] per_buf;
        logic [W-1:0] duty_buf;
        logic         arm;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (per_wr_i)  b_d.per_stage  = wr_data_i;
        if (duty_wr_i) b_d.duty_stage = wr_data_i;
        if (!enabled_i) begin
            b_d.arm = 1'b0;
            if (per_wr_i)  b_d.per_buf  = wr_data_i;
            if (duty_wr_i) b_d.duty_buf = wr_data_i;
        end else begin
            if (wrap_i && b_q.arm) begin
                b_d.per_buf  = b_q.per_stage;
                b_d.duty_buf = b_q.duty_stage;
                b_d.arm      = 1'b0;
            end
            if (duty_wr_i) b_d.arm = 1'b1;
        end
    end

    assign per_buf_o  = b_q.per_buf;
    assign duty_nxt_o = b_d.duty_buf;
    assign armed_o    = b_q.arm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q.per_stage  <= '1;
            b_q.duty_stage <= '0;
            b_q.per_buf    <= '1;
            b_q.duty_buf   <= '0;
            b_q.arm        <= 1'b0;
        end else begin
            b_q <= b_d;
        end
    end
endmodule

// File: rtl/tpt_count_core.sv
module tpt_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         park_i,
    input  logic         trig_i,
    input  logic         tick_i,
    input  logic [W-1:0] per_buf_i,
    input  logic [W-1:0] duty_nxt_i,
    output logic         wrap_o,
    output logic [W-1:0] cnt_o,
    output logic         run_o,
    output logic         pulse_o,
    output logic         tgl_o
);
    localparam logic [W-1:0] PARK_VAL = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         run;
        logic         pulse;
        logic         tgl;
    } core_t;

    core_t c_d, c_q;

    always_comb begin
        c_d    = c_q;
        wrap_o = ~park_i & ~trig_i & c_q.run & tick_i & (c_q.cnt == per_buf_i);
        if (park_i) begin
            c_d.cnt   = PARK_VAL;
            c_d.run   = 1'b0;
            c_d.pulse = 1'b0;
            c_d.tgl   = 1'b0;
        end else begin
            if (trig_i) begin
                c_d.cnt = '0;
                c_d.run = 1'b1;
            end else if (wrap_o) begin
                c_d.cnt = '0;
                c_d.tgl = ~c_q.tgl;
            end else if (c_q.run && tick_i) begin
                c_d.cnt = c_q.cnt + 1'b1;
            end
            c_d.pulse = c_d.run &
                        ((c_d.cnt == duty_nxt_i) | ((c_d.cnt != '0) & c_q.pulse));
        end
    end

    assign cnt_o   = c_q.cnt;
    assign run_o   = c_q.run;
    assign pulse_o = c_q.pulse;
    assign tgl_o   = c_q.tgl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.cnt   <= PARK_VAL;
            c_q.run   <= 1'b0;
            c_q.pulse <= 1'b0;
            c_q.tgl   <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end
endmodule

// File: rtl/trig_pulse_timer.sv
module trig_pulse_timer
    import tpt_pkg::*;
#(
    parameter int W          = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              trig_in,
    input  logic              cnt_tick,
    output logic              pulse_out,
    output logic              period_tgl
);
    typedef struct packed {
        logic en;
        logic fall;
    } ctrl_t;

    ctrl_t k_d, k_q;

    logic         ctrl_wr, per_wr, duty_wr;
    logic         sw_trig, pin_edge, trig;
    logic         wrap;
    logic [W-1:0] per_buf, duty_nxt, cnt_w;
    logic         run_w, armed;

    assign ctrl_wr = wr_en && (wr_addr == SEL_CTRL);
    assign per_wr  = wr_en && (wr_addr == SEL_PERIOD);
    assign duty_wr = wr_en && (wr_addr == SEL_DUTY);

    always_comb begin
        k_d     = k_q;
        sw_trig = 1'b0;
        if (ctrl_wr) begin
            k_d.en   = wr_data[CTRL_EN_BIT];
            k_d.fall = wr_data[CTRL_FALL_BIT];
            sw_trig  = wr_data[CTRL_EN_BIT] & wr_data[CTRL_SWT_BIT];
        end
        trig = k_d.en & (sw_trig | pin_edge);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) k_q <= '0;
        else        k_q <= k_d;
    end

    tpt_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (trig_in),
        .fall_sel_i (k_q.fall),
        .edge_o     (pin_edge)
    );

    tpt_compare_bank #(.W(W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .enabled_i  (k_q.en),
        .per_wr_i   (per_wr),
        .duty_wr_i  (duty_wr),
        .wr_data_i  (wr_data),
        .wrap_i     (wrap),
        .per_buf_o  (per_buf),
        .duty_nxt_o (duty_nxt),
        .armed_o    (armed)
    );

    tpt_count_core #(.W(W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .park_i     (~k_d.en),
        .trig_i     (trig),
        .tick_i     (cnt_tick),
        .per_buf_i  (per_buf),
        .duty_nxt_i (duty_nxt),
        .wrap_o     (wrap),
        .cnt_o      (cnt_w),
        .run_o      (run_w),
        .pulse_o    (pulse_out),
        .tgl_o      (period_tgl)
    );
endmodule

// File: rtl/tpt_checker.sv
module tpt_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en_q,
    input logic         trig,
    input logic         cnt_tick,
    input logic [W-1:0] cnt_w,
    input logic         run_w,
    input logic [W-1:0] per_buf,
    input logic         armed,
    input logic         pulse_out,
    input logic         period_tgl
);
    AST_PARKED_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        !run_w |-> (cnt_w == '1)); // R1

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (!pulse_out && !period_tgl)); // R11

    AST_TRIG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (run_w && cnt_w == '0)); // R10

    AST_RELOAD_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(en_q) && !$stable(per_buf)) |-> $past(armed)); // R9

    AST_TGL_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && $past(run_w) && !$stable(period_tgl))
            |-> $past(cnt_tick && cnt_w == per_buf)); // R7

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && $past(run_w) && !$past(cnt_tick) && !$past(trig))
            |-> $stable(cnt_w)); // R5
endmodule

bind trig_pulse_timer tpt_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_q       (k_q.en),
    .trig       (trig),
    .cnt_tick   (cnt_tick),
    .cnt_w      (cnt_w),
    .run_w      (run_w),
    .per_buf    (per_buf),
    .armed      (armed),
    .pulse_out  (pulse_out),
    .period_tgl (period_tgl)
);

// File: tb/tb_trig_pulse_timer.sv
module tb_trig_pulse_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        trig_in = 1'b0;
    logic        cnt_tick = 1'b1;
    logic        pulse_out, period_tgl;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;

    trig_pulse_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trig_in(trig_in), .cnt_tick(cnt_tick),
        .pulse_out(pulse_out), .period_tgl(period_tgl)
    );

    // reference model of the requirements, advanced on the rising edge
    logic        m_en, m_fall, m_run, m_tgl, m_arm;
    logic [15:0] m_cnt, m_per_s, m_duty_s, m_per_b, m_duty_b;
    logic [2:0]  m_pin;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en <= 0; m_fall <= 0; m_run <= 0; m_tgl <= 0; m_arm <= 0;
            m_cnt <= 16'hFFFF; m_per_s <= 16'hFFFF; m_duty_s <= 0;
            m_per_b <= 16'hFFFF; m_duty_b <= 0; m_pin <= 0;
        end else begin : model_step
            logic edge_v, en_n, sw;
            edge_v = m_fall ? (!m_pin[1] && m_pin[2]) : (m_pin[1] && !m_pin[2]);
            m_pin <= {m_pin[1:0], trig_in};
            en_n = m_en; sw = 0;
            if (wr_en && wr_addr == 2'd0) begin
                en_n = wr_data[0];
                m_fall <= wr_data[2];
                sw = wr_data[0] & wr_data[1];
            end
            m_en <= en_n;
            if (wr_en && wr_addr == 2'd1) m_per_s <= wr_data;
            if (wr_en && wr_addr == 2'd2) m_duty_s <= wr_data;
            if (!m_en) begin
                m_arm <= 0;
                if (wr_en && wr_addr == 2'd1) m_per_b <= wr_data;
                if (wr_en && wr_addr == 2'd2) m_duty_b <= wr_data;
            end else if (wr_en && wr_addr == 2'd2) begin
                m_arm <= 1;
            end
            if (!en_n) begin
                m_cnt <= 16'hFFFF; m_run <= 0; m_tgl <= 0;
            end else if (sw || edge_v) begin
                m_cnt <= 0; m_run <= 1;
            end else if (m_run && cnt_tick) begin
                if (m_cnt == m_per_b) begin
                    m_cnt <= 0; m_tgl <= ~m_tgl;
                    if (m_arm && m_en) begin
                        m_per_b <= m_per_s; m_duty_b <= m_duty_s;
                        if (!(wr_en && wr_addr == 2'd2)) m_arm <= 0;
                    end
                end else begin
                    m_cnt <= m_cnt + 16'd1;
                end
            end
        end
    end

    wire exp_pulse = m_run && (m_cnt >= m_duty_b) && (m_cnt <= m_per_b);

    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (pulse_out !== exp_pulse || period_tgl !== m_tgl) begin
                errors++;
                $display("FAIL %s: pulse/tgl actual %b/%b expected %b/%b (cnt %0d per %0d duty %0d)",
                         cur_req, pulse_out, period_tgl, exp_pulse, m_tgl, m_cnt, m_per_b, m_duty_b);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_data = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (pulse_out !== 0 || period_tgl !== 0) begin
            errors++;
            $display("FAIL R1: reset actual %b/%b expected 0/0", pulse_out, period_tgl);
        end
        cmp_on = 1;
        cur_req = "R1";
        wr(2'd1, 16'd3); wr(2'd2, 16'd0);
        wr(2'd0, 16'h0001);
        idle(12);

        // R8/R6/R7/R4 sweep of period and duty, buffers loaded while disabled
        for (int p = 0; p <= 5; p++) begin
            for (int d = 0; d <= 6; d++) begin
                cur_req = "R8";
                wr(2'd0, 16'h0000);
                wr(2'd1, 16'(p)); wr(2'd2, 16'(d));
                cur_req = "R4";
                wr(2'd0, 16'h0003);
                cur_req = "R6";
                idle(2 * (p + 1) + 3);
            end
        end

        // R5: sparse count strobes
        cur_req = "R5";
        wr(2'd0, 16'h0000); wr(2'd1, 16'd4); wr(2'd2, 16'd2);
        wr(2'd0, 16'h0003);
        for (int i = 0; i < 30; i++) begin
            cnt_tick = (i % 3 == 0);
            @(negedge clk);
        end
        cnt_tick = 1;

        // R2: rising edge on the pin
        cur_req = "R2";
        wr(2'd0, 16'h0000); wr(2'd1, 16'd5); wr(2'd2, 16'd3);
        wr(2'd0, 16'h0001);
        idle(4);
        trig_in = 1; idle(2); trig_in = 0;
        idle(14);

        // R3: falling edge selected
        cur_req = "R3";
        wr(2'd0, 16'h0000);
        trig_in = 1; idle(4);
        wr(2'd0, 16'h0005);
        idle(6);
        trig_in = 0;
        idle(14);

        // R10: retriggers by pin and software while counting
        cur_req = "R10";
        wr(2'd0, 16'h0000); wr(2'd1, 16'd7); wr(2'd2, 16'd4);
        wr(2'd0, 16'h0003);
        idle(5);
        wr(2'd0, 16'h0003);
        idle(3);
        trig_in = 1; idle(3); trig_in = 0; idle(2);
        trig_in = 1; idle(2); trig_in = 0;
        idle(10);
        wr(2'd0, 16'h0000); wr(2'd1, 16'd3); wr(2'd2, 16'd1);
        wr(2'd0, 16'h0003);
        idle(2);
        wr(2'd0, 16'h0003);
        idle(8);

        // R9: staged reload
        cur_req = "R9";
        wr(2'd0, 16'h0000); wr(2'd1, 16'd6); wr(2'd2, 16'd3);
        wr(2'd0, 16'h0003);
        idle(3);
        wr(2'd1, 16'd2);
        idle(20);
        wr(2'd1, 16'd2); wr(2'd2, 16'd1);
        idle(20);
        wr(2'd2, 16'd5);
        idle(12);

        // R11: disable while running
        cur_req = "R11";
        wr(2'd1, 16'd4); wr(2'd2, 16'd0);
        wr(2'd0, 16'h0000);
        idle(10);
        trig_in = 1; idle(5); trig_in = 0; idle(5);

        cmp_on = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule